// File: doc/BRIEF.md
# Programmable 16-bit Counter/Timer

This block is a 16-bit down counter that reloads from a programmable time constant. Software sets it up over a byte-wide register bus. A mode byte chooses single-cycle or continuous operation. It also picks the count source (the system clock or rising edges of an external count input), enables an external trigger and an external gate, enables retriggering, and selects the output waveform: pulse, one-shot or square wave. A command/status byte holds the software gate and trigger bits, a freeze control for reading the count, and a read-only count-in-progress flag.

A count starts on a rising edge of the software trigger bit, or on a rising edge of the external trigger input when that input is enabled. The time constant is then copied into the counter. The counter steps down while gated. At terminal count it raises a one-cycle end-of-count interrupt pulse and updates the waveform. After that it either reloads and runs again or stops. The current count can be frozen, so that software reads its two bytes as one consistent value.

Top module: `ctr_timer16`

## Requirements
- R1: Register map on `bus_addr`: 0 mode, 1 command/status, 2 count high byte, 3 count low byte, 4 time constant high byte, 5 time constant low byte. Mode and time constant read back what was written. After reset every register reads 0, and `tmr_out` and `eoc_irq` are low.
- R2: Writing 1 to command bit 1 (trigger) when it holds 0 copies the time constant into the count and sets status bit 0 (count in progress) at that clock edge. With the clock as the count source, the count then falls by one every cycle while the counter is gated.
- R3: With a time constant N, terminal count comes N count steps after the load. `eoc_irq` is high for exactly the one cycle after that edge. In single-cycle mode (mode bit 7 = 0) the count becomes 0 and the count-in-progress flag clears.
- R4: In continuous mode (mode bit 7 = 1) the count reloads from the time constant at terminal count. `eoc_irq` then pulses every N cycles.
- R5: The counter steps only while command bit 2 (gate) is 1 and, when mode bit 3 is set, `ext_gate` is also high. Otherwise the count holds.
- R6: With mode bit 5 set, the count steps once per rising edge of `ext_cnt` and holds between edges.
- R7: With mode bit 4 set, a rising edge of `ext_trig` starts a count just as the software trigger does. With mode bit 4 clear, `ext_trig` has no effect.
- R8: A trigger during a count reloads the time constant only when mode bit 2 (retrigger) is set. When that bit is clear, the trigger is ignored and the count continues.
- R9: Mode bits 1:0 select the waveform. 0 is pulse: high from terminal count until the next count step. 1 is one-shot: high from terminal count until the next accepted trigger. 2 is square wave: toggles at each terminal count. 3 is reserved and keeps the output low. Any accepted trigger clears the output.
- R10: `tmr_out` is driven only when mode bit 6 is set. With that bit clear it stays low, while `eoc_irq` still pulses.
- R11: Writing 1 to command bit 3 captures the current count. Registers 2 and 3 return the captured value, and status bit 3 reads 1, until a read of register 3 (`bus_rd` high). Counting goes on underneath.
- R12: Writing the time constant during a count does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_rd | input | 1 | Read strobe, used to release the frozen count |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ext_cnt | input | 1 | External count input, rising edges counted |
| ext_trig | input | 1 | External trigger input, rising edge starts a count |
| ext_gate | input | 1 | External gate input, high enables counting |
| tmr_out | output | 1 | Timer waveform output |
| eoc_irq | output | 1 | End-of-count interrupt pulse |

## Verification
A register write takes effect at the clock edge that samples it. A trigger write therefore shows the loaded count at the next falling edge, and the count falls by one at each following edge. With time constant N, `eoc_irq` and the waveform change are due exactly N edges after the load. The freeze capture holds the count from before the decrement in the same edge. The bench drives every input at a falling edge and reads the combinational read data in that same half cycle. It counts edges from the trigger write, so each expected value is computed from N and the elapsed edge count, over sweeps of N and of the mode codes.

// File: rtl/ctr_timer16.sv
module ctr_timer16 #(
  parameter int BW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          ext_cnt,
  input  logic          ext_trig,
  input  logic          ext_gate,
  output logic          tmr_out,
  output logic          eoc_irq
);
  localparam int CW = 2 * BW;
  localparam logic [AW-1:0] A_MODE = 0, A_CMD = 1, A_CNTH = 2, A_CNTL = 3, A_TCH = 4, A_TCL = 5;

  logic [BW-1:0] mode;
  logic [CW-1:0] cnt, tc, frz;
  logic gcb, tcb, cip, frozen, wave, ext_cnt_q, ext_trig_q;

  wire wr_cmd   = bus_wr && bus_addr == A_CMD;
  wire sw_trig  = wr_cmd && bus_wdata[1] && !tcb;
  wire hw_trig  = mode[4] && ext_trig && !ext_trig_q;
  wire trig_acc = (sw_trig || hw_trig) && (!cip || mode[2]);
  wire gate_ok  = gcb && (!mode[3] || ext_gate);
  wire tick     = mode[5] ? (ext_cnt && !ext_cnt_q) : 1'b1;
  wire step     = cip && gate_ok && tick && !trig_acc;
  wire tc_ev    = step && cnt == CW'(1);
  wire [CW-1:0] cnt_v = frozen ? frz : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; cnt <= '0; tc <= '0; frz <= '0;
      gcb <= 1'b0; tcb <= 1'b0; cip <= 1'b0; frozen <= 1'b0;
      wave <= 1'b0; eoc_irq <= 1'b0; ext_cnt_q <= 1'b0; ext_trig_q <= 1'b0;
    end else begin
      ext_cnt_q  <= ext_cnt;
      ext_trig_q <= ext_trig;
      eoc_irq    <= tc_ev;
      if (bus_wr && bus_addr == A_MODE) mode <= bus_wdata;
      if (bus_wr && bus_addr == A_TCH) tc[CW-1:BW] <= bus_wdata;
      if (bus_wr && bus_addr == A_TCL) tc[BW-1:0] <= bus_wdata;
      if (wr_cmd) begin
        gcb <= bus_wdata[2];
        tcb <= bus_wdata[1];
      end

      if (trig_acc) begin
        cnt <= tc;
        cip <= 1'b1;
      end else if (tc_ev) begin
        if (mode[7]) cnt <= tc;
        else begin
          cnt <= '0;
          cip <= 1'b0;
        end
      end else if (step) begin
        cnt <= cnt - CW'(1);
      end

      if (wr_cmd && bus_wdata[3] && !frozen) begin
        frozen <= 1'b1;
        frz    <= cnt;
      end else if (bus_rd && bus_addr == A_CNTL) begin
        frozen <= 1'b0;
      end

      if (trig_acc) wave <= 1'b0;
      else begin
        case (mode[1:0])
          2'd0: if (tc_ev) wave <= 1'b1; else if (tick) wave <= 1'b0;
          2'd1: if (tc_ev) wave <= 1'b1;
          2'd2: if (tc_ev) wave <= !wave;
          default: wave <= 1'b0;
        endcase
      end
    end
  end

  assign tmr_out = mode[6] && wave;

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = mode;
      A_CMD:   bus_rdata = {{(BW-4){1'b0}}, frozen, gcb, tcb, cip};
      A_CNTH:  bus_rdata = cnt_v[CW-1:BW];
      A_CNTL:  bus_rdata = cnt_v[BW-1:0];
      A_TCH:   bus_rdata = tc[CW-1:BW];
      A_TCL:   bus_rdata = tc[BW-1:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ctr_timer16_chk.sv
module ctr_timer16_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cip,
  input logic          trig_acc,
  input logic          gate_ok,
  input logic          frozen,
  input logic          eoc_irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] tc,
  input logic [CW-1:0] frz
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_acc |=> (cnt == $past(tc)) && cip);

  p_eoc_from_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> $past(cip));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cip && !trig_acc) |=> $stable(cnt));

  p_gate_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cip && !gate_ok && !trig_acc) |=> $stable(cnt));

  p_freeze_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> $stable(frz));
endmodule

bind ctr_timer16 ctr_timer16_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cip(cip), .trig_acc(trig_acc), .gate_ok(gate_ok),
  .frozen(frozen), .eoc_irq(eoc_irq), .cnt(cnt), .tc(tc), .frz(frz)
);

// File: tb/tb_ctr_timer16.sv
`timescale 1ns/1ps
module tb_ctr_timer16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic ext_cnt = 1'b0, ext_trig = 1'b0, ext_gate = 1'b0;
  logic tmr_out, eoc_irq;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctr_timer16 dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_cnt(ext_cnt), .ext_trig(ext_trig),
    .ext_gate(ext_gate), .tmr_out(tmr_out), .eoc_irq(eoc_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    ext_cnt = 1'b0; ext_trig = 1'b0; ext_gate = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; #0.1; d = bus_rdata;
  endtask

  task automatic rd_edge(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1; #0.1; d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic get_cnt(output int v);
    logic [7:0] h, l;
    peek(3'd2, h); peek(3'd3, l);
    v = {h, l};
  endtask

  task automatic get_cip(output int v);
    logic [7:0] s;
    peek(3'd1, s);
    v = s[0];
  endtask

  task automatic setup(input logic [7:0] md, input int n);
    do_reset();
    wr(3'd0, md); wr(3'd4, 8'(n >> 8)); wr(3'd5, 8'(n));
  endtask

  task automatic start();
    wr(3'd1, 8'h04); wr(3'd1, 8'h06);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int v, c;
    logic [7:0] d;
    do_reset();
    // R1 reset values and readback
    for (int a = 0; a < 6; a++) begin peek(3'(a), d); check("R1 reset reg", d, 0); end
    check("R1 reset out", tmr_out, 0); check("R1 reset eoc", eoc_irq, 0);
    wr(3'd0, 8'hA5); peek(3'd0, d); check("R1 mode readback", d, 8'hA5);
    wr(3'd4, 8'h12); peek(3'd4, d); check("R1 tc high readback", d, 8'h12);

    // R2 R3 R9 single-cycle pulse sweep
    for (int n = 1; n <= 12; n++) begin
      setup(8'h40, n); start();
      for (int m = 0; m <= n + 1; m++) begin
        if (m > 0) @(negedge clk);
        get_cnt(v); get_cip(c);
        check("R2 count", v, (m < n) ? n - m : 0);
        check("R3 cip", c, (m < n) ? 1 : 0);
        check("R3 eoc", eoc_irq, (m == n) ? 1 : 0);
        check("R9 pulse out", tmr_out, (m == n) ? 1 : 0);
      end
    end

    // R4 continuous reload
    for (int n = 3; n <= 6; n++) begin
      setup(8'hC0, n); start();
      for (int m = 0; m <= 3 * n + 1; m++) begin
        if (m > 0) @(negedge clk);
        get_cnt(v);
        check("R4 count", v, n - (m % n));
        check("R4 eoc", eoc_irq, (m > 0 && m % n == 0) ? 1 : 0);
      end
    end

    // R10 output disabled
    setup(8'h80, 3); start(); idle(3);
    check("R10 eoc with out off", eoc_irq, 1); check("R10 out off", tmr_out, 0);

    // R9 square wave
    setup(8'hC2, 4); start();
    for (int m = 0; m <= 12; m++) begin
      if (m > 0) @(negedge clk);
      check("R9 square", tmr_out, (m / 4) % 2);
    end

    // R9 one-shot
    setup(8'h41, 5); start();
    for (int m = 0; m <= 10; m++) begin
      if (m > 0) @(negedge clk);
      check("R9 one-shot", tmr_out, (m >= 5) ? 1 : 0);
    end
    wr(3'd1, 8'h04); check("R9 one-shot hold", tmr_out, 1);
    wr(3'd1, 8'h06); check("R9 one-shot cleared", tmr_out, 0);
    get_cnt(v); check("R2 reload on trigger", v, 5);

    // R9 reserved code
    setup(8'h43, 3); start(); idle(3);
    check("R9 reserved eoc", eoc_irq, 1); check("R9 reserved out", tmr_out, 0);

    // R5 software gate
    setup(8'h40, 30); start(); idle(2);
    wr(3'd1, 8'h02); get_cnt(v); check("R5 last step", v, 27);
    idle(4); get_cnt(v); check("R5 gate off hold", v, 27);
    wr(3'd1, 8'h06); get_cnt(v); check("R5 gate reopen no retrig", v, 27);
    idle(1); get_cnt(v); check("R5 gate on step", v, 26);

    // R5 external gate
    setup(8'h48, 10); start(); idle(3);
    get_cnt(v); check("R5 ext gate low hold", v, 10);
    ext_gate = 1'b1; idle(3);
    get_cnt(v); check("R5 ext gate high count", v, 7);

    // R6 external count
    setup(8'h60, 3); start(); idle(4);
    get_cnt(v); check("R6 no edges hold", v, 3);
    for (int p = 0; p < 2; p++) begin
      ext_cnt = 1'b1; @(negedge clk); ext_cnt = 1'b0; @(negedge clk);
    end
    get_cnt(v); check("R6 two edges", v, 1);
    ext_cnt = 1'b1; @(negedge clk);
    check("R6 eoc on third edge", eoc_irq, 1);
    ext_cnt = 1'b0; @(negedge clk);
    check("R9 pulse spans count period", tmr_out, 1);

    // R7 external trigger
    setup(8'h50, 7); wr(3'd1, 8'h04);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
    get_cnt(v); get_cip(c);
    check("R7 ext trig load", v, 7); check("R7 ext trig cip", c, 1);
    setup(8'h40, 7); wr(3'd1, 8'h04);
    ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0; idle(2);
    get_cnt(v); get_cip(c);
    check("R7 disabled count", v, 0); check("R7 disabled cip", c, 0);

    // R8 retrigger
    setup(8'h44, 20); start(); idle(5);
    wr(3'd1, 8'h04); wr(3'd1, 8'h06);
    get_cnt(v); check("R8 retrigger reload", v, 20);
    setup(8'h40, 20); start(); idle(5);
    wr(3'd1, 8'h04); wr(3'd1, 8'h06);
    get_cnt(v); check("R8 trigger ignored", v, 13);

    // R12 time constant write during count
    setup(8'h40, 30); start(); idle(3);
    wr(3'd5, 8'd5);
    get_cnt(v); check("R12 count undisturbed", v, 26);
    peek(3'd5, d); check("R12 tc updated", d, 5);

    // R11 freeze for readback
    setup(8'h00, 200); start(); idle(10);
    wr(3'd1, 8'h0E); idle(5);
    peek(3'd1, d); check("R11 freeze flag", d[3], 1);
    peek(3'd2, d); check("R11 frozen high", d, 0);
    rd_edge(3'd3, d); check("R11 frozen low", d, 190);
    peek(3'd1, d); check("R11 released flag", d[3], 0);
    get_cnt(v); check("R11 live after release", v, 183);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule